// File: doc/BRIEF.md
# Monochrome STN Panel Scan Controller

This block generates the scan timing for a passive-matrix monochrome panel of H_DOTS by V_LINES dots (320 by 240 by default, at 1/240 duty) that takes pixels over a BUS_W-bit (4-bit) parallel bus. It fetches one pixel word per column from an external frame-buffer read port and drives that word onto the panel data bus. It also produces the column shift clock, the line latch pulse, the first-line marker and the AC inversion signal for the panel's segment and common drivers.

A power sequencer controls the panel's active-low blanking output and the enable of the external high-voltage supply. On power-up the supply is enabled while the panel stays blanked, and blanking is released after a settle delay. On power-down the panel is blanked first and the supply is removed after the same delay. Scanning runs only while the panel is unblanked. Each power-up restarts the scan at line 0, column 0.

The frame-buffer port has a fixed latency and no back-pressure. A word is requested with `rd_en` and `rd_addr`, and the memory must present it on `rd_data` in the following cycle. The controller never stalls, so the memory must always accept a request and answer it on time.

Top module: `stn_panel_scan`

## Requirements
- R1: After reset, `hv_en`, `blank_n`, `rd_en`, `shift_clk`, `line_latch`, `frame_start`, `ac_invert` and `px_data` are all 0, and `seq_done` is 1.
- R2: When `power_req` is seen high while the sequencer is off, `hv_en` rises in the next cycle while `blank_n` stays 0. `blank_n` rises exactly SETTLE_CYC cycles after `hv_en` rose.
- R3: When `power_req` is seen low while the panel is on, `blank_n` falls in the next cycle. `hv_en` stays 1 for SETTLE_CYC cycles and then falls.
- R4: `seq_done` is 0 only while a ramp (up or down) is in progress. Changes of `power_req` during a ramp have no effect until that ramp completes.
- R5: A line carries COLS = H_DOTS/BUS_W pulses of `shift_clk`. Each pulse is high for one cycle after a cycle low, and `px_data` is stable while `shift_clk` is high.
- R6: Column c of line L is requested with one `rd_en` cycle at address L*COLS + c, in column order. The returned word appears on `px_data` two cycles after the request, in the cycle before the matching `shift_clk` high.
- R7: After the last shift pulse of a line, `line_latch` is high for LP_W cycles. `line_latch` and `shift_clk` are never high together. A line lasts 2*COLS + LP_W cycles.
- R8: `frame_start` is high exactly during the `line_latch` pulse that ends line V_LINES-1.
- R9: `ac_invert` toggles once per frame, in the cycle where the `line_latch` pulse ending the last line begins. At all other times it holds its value, including across power cycles.
- R10: `rd_en` is high only while `blank_n` is 1. Each power-up restarts the scan at line 0, column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_req | input | 1 | 1 requests panel on, 0 requests panel off |
| rd_en | output | 1 | Frame-buffer read request |
| rd_addr | output | AW | Linear word address, line*COLS + column |
| rd_data | input | BUS_W | Frame-buffer word, valid the cycle after rd_en |
| px_data | output | BUS_W | Panel pixel data bus |
| shift_clk | output | 1 | Column shift clock, data taken on its high phase |
| line_latch | output | 1 | Line latch pulse |
| frame_start | output | 1 | First-line marker for the common driver chain |
| ac_invert | output | 1 | Frame AC inversion signal |
| blank_n | output | 1 | Active-low display blanking |
| hv_en | output | 1 | Enable for the external high-voltage supply |
| seq_done | output | 1 | 1 when no power ramp is in progress |

## Verification
The hardest situations to reach are a change of request that lands in the middle of a ramp, and a power-down that cuts a line short part-way through. Both leave state that only shows up later, at the next power-up. The stimulus toggles `power_req` two cycles into an up-ramp and again inside the down-ramp, then drops power in mid-line after several frames. A behavioural model that counts cycles checks every output on every cycle, including the two-cycle tail of the output stage after blanking and the restart at line 0 that follows.

// File: rtl/stn_scan_pkg.sv
package stn_scan_pkg;
  typedef enum logic [1:0] {
    PWR_OFF     = 2'd0,
    PWR_RAMP_UP = 2'd1,
    PWR_ON      = 2'd2,
    PWR_RAMP_DN = 2'd3
  } pwr_state_t;
endpackage

// File: rtl/stn_power_seq.sv
module stn_power_seq
  import stn_scan_pkg::*;
#(
  parameter int SETTLE_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic power_req,
  output logic scan_en,
  output logic hv_en,
  output logic blank_n,
  output logic seq_done
);
  localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_CYC - 1);

  pwr_state_t state;
  logic [CW-1:0] settle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= PWR_OFF;
      settle_cnt <= '0;
    end else begin
      case (state)
        PWR_OFF: if (power_req) begin
          state      <= PWR_RAMP_UP;
          settle_cnt <= '0;
        end
        PWR_RAMP_UP: if (settle_cnt == CNT_LAST) state <= PWR_ON;
                     else settle_cnt <= settle_cnt + 1'b1;
        PWR_ON: if (!power_req) begin
          state      <= PWR_RAMP_DN;
          settle_cnt <= '0;
        end
        default: if (settle_cnt == CNT_LAST) state <= PWR_OFF;
                 else settle_cnt <= settle_cnt + 1'b1;
      endcase
    end
  end

  assign scan_en  = (state == PWR_ON);
  assign blank_n  = (state == PWR_ON);
  assign hv_en    = (state != PWR_OFF);
  assign seq_done = (state == PWR_OFF) || (state == PWR_ON);

  // Unblanking happens only once the supply has been up for a cycle or more
  assert_unblank_after_hv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blank_n) |-> (hv_en && $past(hv_en)));
  // Supply removal only ever follows blanking
  assert_hv_off_blanked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hv_en) |-> $past(!blank_n));
  // A ramp in progress runs to its end whatever the request does
  assert_ramp_up_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PWR_RAMP_UP) |=> (state == PWR_RAMP_UP || state == PWR_ON));
  assert_ramp_dn_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PWR_RAMP_DN) |=> (state == PWR_RAMP_DN || state == PWR_OFF));
endmodule

// File: rtl/stn_scan_counter.sv
module stn_scan_counter #(
  parameter int COLS    = 80,
  parameter int V_LINES = 240,
  parameter int LP_W    = 2,
  parameter int AW      = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic          shift_pre,
  output logic          latch_pre,
  output logic          start_pre,
  output logic          flip_pre
);
  localparam int LINE_LEN = 2 * COLS + LP_W;
  localparam int LW = $clog2(LINE_LEN);
  localparam int VW = $clog2(V_LINES);
  localparam logic [LW-1:0] DATA_END  = LW'(2 * COLS);
  localparam logic [LW-1:0] LAST_CYC  = LW'(LINE_LEN - 1);
  localparam logic [VW-1:0] LAST_LINE = VW'(V_LINES - 1);

  logic [LW-1:0] cyc;
  logic [VW-1:0] line;
  logic [AW-1:0] base;
  logic          in_data;
  logic          last_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc  <= '0;
      line <= '0;
      base <= '0;
    end else if (!en) begin
      cyc  <= '0;
      line <= '0;
      base <= '0;
    end else if (cyc == LAST_CYC) begin
      cyc <= '0;
      if (line == LAST_LINE) begin
        line <= '0;
        base <= '0;
      end else begin
        line <= line + 1'b1;
        base <= base + AW'(COLS);
      end
    end else begin
      cyc <= cyc + 1'b1;
    end
  end

  always_comb begin
    last_line = (line == LAST_LINE);
    in_data   = en && (cyc < DATA_END);
    rd_req    = in_data && !cyc[0];
    shift_pre = in_data && cyc[0];
    latch_pre = en && (cyc >= DATA_END);
    start_pre = latch_pre && last_line;
    flip_pre  = en && (cyc == DATA_END) && last_line;
    rd_addr   = base + AW'(cyc >> 1);
  end
endmodule

// File: rtl/stn_out_stage.sv
module stn_out_stage #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic          shift_pre,
  input  logic          latch_pre,
  input  logic          start_pre,
  input  logic          flip_pre,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] px_data,
  output logic          shift_clk,
  output logic          line_latch,
  output logic          frame_start,
  output logic          ac_invert
);
  logic p_load, p_shift, p_latch, p_start, p_flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_load <= 1'b0; p_shift <= 1'b0; p_latch <= 1'b0;
      p_start <= 1'b0; p_flip <= 1'b0;
      px_data <= '0; shift_clk <= 1'b0; line_latch <= 1'b0;
      frame_start <= 1'b0; ac_invert <= 1'b0;
    end else begin
      p_load  <= rd_req;
      p_shift <= shift_pre;
      p_latch <= latch_pre;
      p_start <= start_pre;
      p_flip  <= flip_pre;
      if (p_load) px_data <= rd_data;
      shift_clk   <= p_shift;
      line_latch  <= p_latch;
      frame_start <= p_start;
      if (p_flip) ac_invert <= !ac_invert;
    end
  end

  assert_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_clk |-> $stable(px_data));
  assert_shift_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_clk |=> !shift_clk);
  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_clk && line_latch));
  assert_start_in_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> line_latch);
  assert_invert_at_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ac_invert != $past(ac_invert)) |-> (frame_start && !$past(line_latch)));
endmodule

// File: rtl/stn_panel_scan.sv
module stn_panel_scan #(
  parameter int H_DOTS     = 320,
  parameter int V_LINES    = 240,
  parameter int BUS_W      = 4,
  parameter int LP_W       = 2,
  parameter int SETTLE_CYC = 1000,
  localparam int COLS      = H_DOTS / BUS_W,
  localparam int AW        = $clog2(COLS * V_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             power_req,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  input  logic [BUS_W-1:0] rd_data,
  output logic [BUS_W-1:0] px_data,
  output logic             shift_clk,
  output logic             line_latch,
  output logic             frame_start,
  output logic             ac_invert,
  output logic             blank_n,
  output logic             hv_en,
  output logic             seq_done
);
  logic scan_en, shift_pre, latch_pre, start_pre, flip_pre;

  stn_power_seq #(.SETTLE_CYC(SETTLE_CYC)) u_pwr (
    .clk(clk), .rst_n(rst_n), .power_req(power_req),
    .scan_en(scan_en), .hv_en(hv_en), .blank_n(blank_n), .seq_done(seq_done)
  );

  stn_scan_counter #(.COLS(COLS), .V_LINES(V_LINES), .LP_W(LP_W), .AW(AW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(scan_en),
    .rd_req(rd_en), .rd_addr(rd_addr),
    .shift_pre(shift_pre), .latch_pre(latch_pre),
    .start_pre(start_pre), .flip_pre(flip_pre)
  );

  stn_out_stage #(.DW(BUS_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .rd_req(rd_en), .shift_pre(shift_pre), .latch_pre(latch_pre),
    .start_pre(start_pre), .flip_pre(flip_pre), .rd_data(rd_data),
    .px_data(px_data), .shift_clk(shift_clk), .line_latch(line_latch),
    .frame_start(frame_start), .ac_invert(ac_invert)
  );

  assert_read_unblanked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> blank_n);
  assert_addr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (int'(rd_addr) < COLS * V_LINES));
endmodule

// File: tb/stn_panel_scan_bench.sv
module stn_panel_scan_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H  = 16;
  localparam int V  = 4;
  localparam int BW = 4;
  localparam int LP = 2;
  localparam int ST = 5;
  localparam int C  = H / BW;
  localparam int LL = 2 * C + LP;
  localparam int AW = $clog2(C * V);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic power_req = 1'b0;
  logic rd_en;
  logic [AW-1:0] rd_addr;
  logic [BW-1:0] rd_data = '0;
  logic [BW-1:0] px_data;
  logic shift_clk, line_latch, frame_start, ac_invert, blank_n, hv_en, seq_done;

  int checks = 0;
  int failures = 0;
  bit cmp_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stn_panel_scan #(.H_DOTS(H), .V_LINES(V), .BUS_W(BW), .LP_W(LP), .SETTLE_CYC(ST)) u_stn_panel_scan (
    .clk(clk), .rst_n(rst_n), .power_req(power_req),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .px_data(px_data), .shift_clk(shift_clk), .line_latch(line_latch),
    .frame_start(frame_start), .ac_invert(ac_invert),
    .blank_n(blank_n), .hv_en(hv_en), .seq_done(seq_done)
  );

  function automatic int fb(int i);
    return (i * 5 + 3) % 16;
  endfunction

  // frame-buffer model with one cycle of latency
  always @(posedge clk) if (rd_en) rd_data <= BW'(fb(int'(rd_addr)));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: power state, scan position, two-cycle output tail
  int ms = 0, mc = 0, sc = 0, ln = 0;
  int q_load = 0, q_data = 0, q_sh = 0, q_la = 0, q_st = 0, q_fl = 0;
  int e_db = 0, e_sh = 0, e_la = 0, e_st = 0, e_m = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mc = 0; sc = 0; ln = 0;
      q_load = 0; q_data = 0; q_sh = 0; q_la = 0; q_st = 0; q_fl = 0;
      e_db = 0; e_sh = 0; e_la = 0; e_st = 0; e_m = 0;
    end else begin
      e_sh = q_sh; e_la = q_la; e_st = q_st;
      if (q_load != 0) e_db = q_data;
      if (q_fl != 0) e_m = 1 - e_m;
      q_load = (ms == 2 && sc < 2 * C && sc % 2 == 0) ? 1 : 0;
      q_data = fb(ln * C + sc / 2);
      q_sh   = (ms == 2 && sc < 2 * C && sc % 2 == 1) ? 1 : 0;
      q_la   = (ms == 2 && sc >= 2 * C) ? 1 : 0;
      q_st   = (q_la != 0 && ln == V - 1) ? 1 : 0;
      q_fl   = (ms == 2 && sc == 2 * C && ln == V - 1) ? 1 : 0;
      if (ms == 2) begin
        sc++;
        if (sc == LL) begin sc = 0; ln = (ln + 1) % V; end
      end else begin
        sc = 0; ln = 0;
      end
      case (ms)
        0: if (power_req) begin ms = 1; mc = 0; end
        1: if (mc == ST - 1) ms = 2; else mc++;
        2: if (!power_req) begin ms = 3; mc = 0; end
        default: if (mc == ST - 1) ms = 0; else mc++;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      int erd;
      erd = (ms == 2 && sc < 2 * C && sc % 2 == 0) ? 1 : 0;
      chk("R2 blank_n", int'(blank_n), (ms == 2) ? 1 : 0);
      chk("R3 hv_en", int'(hv_en), (ms != 0) ? 1 : 0);
      chk("R4 seq_done", int'(seq_done), (ms == 0 || ms == 2) ? 1 : 0);
      chk("R10 rd_en", int'(rd_en), erd);
      if (erd != 0) chk("R6 rd_addr", int'(rd_addr), ln * C + sc / 2);
      chk("R6 px_data", int'(px_data), e_db);
      chk("R5 shift_clk", int'(shift_clk), e_sh);
      chk("R7 line_latch", int'(line_latch), e_la);
      chk("R8 frame_start", int'(frame_start), e_st);
      chk("R9 ac_invert", int'(ac_invert), e_m);
    end
  end

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_cyc(3);
    // R1: reset values
    chk("R1 hv_en", int'(hv_en), 0);
    chk("R1 blank_n", int'(blank_n), 0);
    chk("R1 seq_done", int'(seq_done), 1);
    chk("R1 rd_en", int'(rd_en), 0);
    chk("R1 outputs", int'({shift_clk, line_latch, frame_start, ac_invert}), 0);
    chk("R1 px_data", int'(px_data), 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    wait_cyc(3);
    power_req = 1'b1;            // R2 up-ramp
    wait_cyc(3);
    power_req = 1'b0;            // R4 dropped mid-ramp: ignored
    wait_cyc(8);                 // on briefly, then down-ramp
    power_req = 1'b1;            // R4 raised mid down-ramp: ignored
    wait_cyc(ST + 4);            // off, then ramp up again
    wait_cyc(ST + 3 * V * LL + 7);   // several frames, R5..R9
    power_req = 1'b0;            // R3 / R10 power-down mid-line
    wait_cyc(ST + 6);
    power_req = 1'b1;            // R10 restart at line 0
    wait_cyc(ST + 2 * V * LL + 3);
    power_req = 1'b0;
    wait_cyc(ST + 4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule